// File: doc/BRIEF.md
# Big-Endian Load/Store Lane Aligner

This block sits between a 32-bit processor datapath and a data memory that is one word wide, byte addressed and synchronous. On each request it turns a byte address, an access size and a signedness flag into a word-index memory request. For stores it places the low bits of the source register in the right byte lane and drives per-byte write strobes. For loads it waits the one cycle the memory needs, picks the requested lane from the returned word, and sign- or zero-extends it to 32 bits.

Lanes follow big-endian order: within a word, byte offset 0 is the most-significant byte. An access whose address does not suit its size is never sent to memory. Instead a misalignment pulse appears in the cycle where load data would have appeared.

Top module: `be_lsu_align`

## Requirements
- R1: A request with `req_valid` high and a suitably aligned address asserts `mem_en` in the same cycle, with `mem_addr` equal to `req_addr[31:2]` and `mem_we` equal to `req_write`.
- R2: A byte store (size code 0) at byte offset k = `req_addr[1:0]` asserts only strobe bit `mem_be[3-k]` and puts `req_wdata[7:0]` on `mem_wdata[31-8k:24-8k]`.
- R3: A halfword store (size code 1) at offset 0 drives `mem_be` = 4'b1100 with `req_wdata[15:0]` on `mem_wdata[31:16]`; at offset 2 it drives 4'b0011 with the data on `mem_wdata[15:0]`.
- R4: A word store (size code 2) drives `mem_be` = 4'b1111 and `mem_wdata` = `req_wdata`.
- R5: A signed byte load returns the byte at its offset, with bit 7 copied into bits 31:8.
- R6: An unsigned byte or halfword load (`req_unsigned` = 1) returns the selected lane with all upper bits zero.
- R7: A signed halfword load returns the two bytes starting at the even offset, with the lower-addressed byte in bits 15:8 and bit 15 copied into bits 31:16.
- R8: A word load returns the full memory word unchanged, with offset 0 in bits 31:24.
- R9: `ld_valid` rises exactly one cycle after an aligned load request, together with `ld_data`. It is low in every other cycle.
- R10: A halfword at an odd address, or a word at an address that is not a multiple of 4, is misaligned. Such a request keeps `mem_en` low and `mem_be` at zero, pulses `misalign` for one cycle on the next cycle, produces no `ld_valid`, and leaves memory unchanged.
- R11: While `rst_n` is low and immediately after reset, `ld_valid` and `misalign` are low.
- R12: Size code 3 is treated exactly as a word access, for alignment, for strobes and for load data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 0 byte, 1 halfword, 2 or 3 word |
| req_unsigned | input | 1 | Zero-extend narrow loads when high |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 32 | Store source register |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 30 | Word index |
| mem_be | output | 4 | Byte strobes; bit 3 is offset 0 |
| mem_wdata | output | 32 | Lane-placed store data |
| mem_rdata | input | 32 | Word read, one cycle after `mem_en` |
| ld_valid | output | 1 | Load result valid |
| ld_data | output | 32 | Extended load result |
| misalign | output | 1 | One-cycle misaligned-access pulse |

## Verification
The assertions assume that `mem_rdata` holds the addressed word in the cycle after `mem_en`. They also assume that `req_size` and `req_addr` are stable whenever `req_valid` is high. The stimulus meets both conditions. The modelled memory registers its read data on the same edge that consumes the request. Inputs change only on the falling clock edge. The requests mix every size code, both signedness flags, all four offsets and high address bits, and include deliberate misaligned halfword and word accesses.

// File: rtl/be_align_pkg.sv
package be_align_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_WIDE = 2'd3
    } acc_size_e;

endpackage

// File: rtl/be_align_check.sv
module be_align_check
    import be_align_pkg::*;
#(
    parameter int OFF_W = 2
) (
    input  acc_size_e          size_i,
    input  logic [OFF_W-1:0]   off_i,
    output logic               aligned_o
);

    // Byte: any offset. Halfword: even offset. Word (and code 3): offset zero.
    always_comb begin
        unique case (size_i)
            SZ_BYTE: aligned_o = 1'b1;
            SZ_HALF: aligned_o = ~off_i[0];
            default: aligned_o = (off_i == '0);
        endcase
    end

endmodule

// File: rtl/be_store_lane.sv
module be_store_lane
    import be_align_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int LANES = DATA_W / 8,
    localparam int OFF_W = $clog2(LANES)
) (
    input  acc_size_e          size_i,
    input  logic [OFF_W-1:0]   off_i,
    input  logic               en_i,
    input  logic [DATA_W-1:0]  wdata_i,
    output logic [DATA_W-1:0]  lane_o,
    output logic [LANES-1:0]   strb_o
);

    // Lane g holds the byte at offset g, starting at the MSB end of the word.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        localparam int MSB = DATA_W - 1 - 8 * g;
        localparam logic [OFF_W-1:0] IDX = OFF_W'(g);

        logic       hit;
        logic [7:0] byte_v;

        always_comb begin
            unique case (size_i)
                SZ_BYTE: begin
                    hit    = (off_i == IDX);
                    byte_v = wdata_i[7:0];
                end
                SZ_HALF: begin
                    hit    = (off_i[OFF_W-1:1] == IDX[OFF_W-1:1]);
                    byte_v = IDX[0] ? wdata_i[7:0] : wdata_i[15:8];
                end
                default: begin
                    hit    = 1'b1;
                    byte_v = wdata_i[MSB -: 8];
                end
            endcase
        end

        assign lane_o[MSB -: 8]    = hit ? byte_v : 8'h00;
        assign strb_o[LANES-1-g]   = hit & en_i;
    end

endmodule

// File: rtl/be_load_lane.sv
module be_load_lane
    import be_align_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int LANES = DATA_W / 8,
    localparam int OFF_W = $clog2(LANES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               issue_i,
    input  logic               flag_i,
    input  acc_size_e          size_i,
    input  logic               uns_i,
    input  logic [OFF_W-1:0]   off_i,
    input  logic [DATA_W-1:0]  rdata_i,
    output logic               vld_o,
    output logic               mis_o,
    output logic [DATA_W-1:0]  data_o
);

    typedef struct packed {
        logic             vld;
        logic             mis;
        logic             uns;
        acc_size_e        size;
        logic [OFF_W-1:0] off;
    } ld_state_t;

    ld_state_t state_d, state_q;

    always_comb begin
        state_d      = state_q;
        state_d.vld  = issue_i;
        state_d.mis  = flag_i;
        if (issue_i) begin
            state_d.uns  = uns_i;
            state_d.size = size_i;
            state_d.off  = off_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '{vld: 1'b0, mis: 1'b0, uns: 1'b0, size: SZ_WORD, off: '0};
        end else begin
            state_q <= state_d;
        end
    end

    logic [OFF_W-1:0] half_off;
    logic [7:0]       byte_sel;
    logic [15:0]      half_sel;

    assign half_off = {state_q.off[OFF_W-1:1], 1'b0};
    assign byte_sel = rdata_i[(DATA_W - 1 - 8 * int'(state_q.off)) -: 8];
    assign half_sel = rdata_i[(DATA_W - 1 - 8 * int'(half_off)) -: 16];

    always_comb begin
        unique case (state_q.size)
            SZ_BYTE: data_o = {{(DATA_W-8){~state_q.uns & byte_sel[7]}}, byte_sel};
            SZ_HALF: data_o = {{(DATA_W-16){~state_q.uns & half_sel[15]}}, half_sel};
            default: data_o = rdata_i;
        endcase
    end

    assign vld_o = state_q.vld;
    assign mis_o = state_q.mis;

    AST_HALF_SIGN_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_o && !state_q.uns && state_q.size == SZ_HALF)
            |-> (data_o[DATA_W-1:16] == {(DATA_W-16){data_o[15]}})); // R7

    AST_VALID_NOT_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        mis_o |-> !vld_o); // R10

endmodule

// File: rtl/be_lsu_align.sv
module be_lsu_align
    import be_align_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    localparam int LANES = DATA_W / 8,
    localparam int OFF_W = $clog2(LANES)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    input  logic                   req_write,
    input  logic [1:0]             req_size,
    input  logic                   req_unsigned,
    input  logic [ADDR_W-1:0]      req_addr,
    input  logic [DATA_W-1:0]      req_wdata,
    output logic                   mem_en,
    output logic                   mem_we,
    output logic [ADDR_W-OFF_W-1:0] mem_addr,
    output logic [LANES-1:0]       mem_be,
    output logic [DATA_W-1:0]      mem_wdata,
    input  logic [DATA_W-1:0]      mem_rdata,
    output logic                   ld_valid,
    output logic [DATA_W-1:0]      ld_data,
    output logic                   misalign
);

    acc_size_e        size_e;
    logic [OFF_W-1:0] off;
    logic             aligned;
    logic             go;

    assign size_e = acc_size_e'(req_size);
    assign off    = req_addr[OFF_W-1:0];

    be_align_check #(.OFF_W(OFF_W)) u_check (
        .size_i    (size_e),
        .off_i     (off),
        .aligned_o (aligned)
    );

    assign go       = req_valid & aligned;
    assign mem_en   = go;
    assign mem_we   = go & req_write;
    assign mem_addr = req_addr[ADDR_W-1:OFF_W];

    be_store_lane #(.DATA_W(DATA_W)) u_store (
        .size_i  (size_e),
        .off_i   (off),
        .en_i    (go & req_write),
        .wdata_i (req_wdata),
        .lane_o  (mem_wdata),
        .strb_o  (mem_be)
    );

    be_load_lane #(.DATA_W(DATA_W)) u_load (
        .clk     (clk),
        .rst_n   (rst_n),
        .issue_i (go & ~req_write),
        .flag_i  (req_valid & ~aligned),
        .size_i  (size_e),
        .uns_i   (req_unsigned),
        .off_i   (off),
        .rdata_i (mem_rdata),
        .vld_o   (ld_valid),
        .mis_o   (misalign),
        .data_o  (ld_data)
    );

    AST_EN_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        mem_en |-> req_valid); // R1

    AST_BYTE_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && size_e == SZ_BYTE) |-> ($countones(mem_be) == 1)); // R2

    AST_HALF_STROBE_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && size_e == SZ_HALF)
            |-> (mem_be == 4'b1100 || mem_be == 4'b0011)); // R3

    AST_WORD_ALL_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && (size_e == SZ_WORD || size_e == SZ_WIDE)) |-> (&mem_be)); // R4

    AST_ODD_HALF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && size_e == SZ_HALF && req_addr[0])
            |-> (!mem_en && mem_be == '0)); // R10

    AST_LOAD_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        ld_valid |-> $past(mem_en && !mem_we)); // R9

    AST_LOAD_FOLLOWS_REQ_FWD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && !mem_we) |=> ld_valid); // R9

    AST_FLAG_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (misalign && !$past(req_valid)) |-> 1'b0); // R10

endmodule

// File: tb/be_lsu_align_test.sv
module be_lsu_align_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [1:0]  req_size = 2'd0;
    logic        req_unsigned = 1'b0;
    logic [31:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        mem_en, mem_we;
    logic [29:0] mem_addr;
    logic [3:0]  mem_be;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata;
    logic        ld_valid, misalign;
    logic [31:0] ld_data;

    int tests = 0;
    int fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    be_lsu_align uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_size(req_size),
        .req_unsigned(req_unsigned), .req_addr(req_addr), .req_wdata(req_wdata),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .ld_valid(ld_valid), .ld_data(ld_data), .misalign(misalign)
    );

    // Word-wide synchronous memory with byte strobes (16 words)
    logic [31:0] mem_words [16];
    always @(posedge clk) begin
        if (mem_en) begin
            if (mem_we) begin
                for (int b = 0; b < 4; b++)
                    if (mem_be[b]) mem_words[mem_addr[3:0]][8*b +: 8] <= mem_wdata[8*b +: 8];
            end
            mem_rdata <= mem_words[mem_addr[3:0]];
        end
    end

    // Behavioural reference: plain byte array, lowest address = most significant
    byte unsigned ref_bytes [64];

    logic        exp_vld = 1'b0;
    logic        exp_mis = 1'b0;
    logic [31:0] exp_data = '0;
    string       exp_tag = "R11";

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] ref_load(input logic [1:0] sz, input bit uns, input logic [31:0] a);
        int i = int'(a[5:0]);
        logic [7:0]  b;
        logic [15:0] h;
        case (sz)
            2'd0: begin b = ref_bytes[i]; return uns ? {24'h0, b} : {{24{b[7]}}, b}; end
            2'd1: begin h = {ref_bytes[i], ref_bytes[i+1]}; return uns ? {16'h0, h} : {{16{h[15]}}, h}; end
            default: return {ref_bytes[i], ref_bytes[i+1], ref_bytes[i+2], ref_bytes[i+3]};
        endcase
    endfunction

    function automatic bit is_aligned(input logic [1:0] sz, input logic [31:0] a);
        if (sz == 2'd0) return 1'b1;
        if (sz == 2'd1) return !a[0];
        return a[1:0] == 2'b00;
    endfunction

    function automatic string ld_tag(input logic [1:0] sz, input bit uns);
        if (sz == 2'd3) return "R12";
        if (sz == 2'd2) return "R8";
        if (uns) return "R6";
        return (sz == 2'd0) ? "R5" : "R7";
    endfunction

    task automatic check_pending();
        chk(ld_valid === exp_vld, "R9", {31'h0, ld_valid}, {31'h0, exp_vld});
        chk(misalign === exp_mis, "R10", {31'h0, misalign}, {31'h0, exp_mis});
        if (exp_vld) chk(ld_data === exp_data, exp_tag, ld_data, exp_data);
    endtask

    task automatic issue(input bit v, input bit w, input logic [1:0] sz, input bit uns,
                         input logic [31:0] a, input logic [31:0] wd);
        bit al;
        logic [3:0]  ebe;
        logic [31:0] ewd;
        int k;
        @(negedge clk);
        check_pending();
        req_valid = v; req_write = w; req_size = sz; req_unsigned = uns;
        req_addr = a; req_wdata = wd;
        #1;
        al = is_aligned(sz, a);
        k  = int'(a[1:0]);
        chk(mem_en === (v && al), al ? "R1" : "R10", {31'h0, mem_en}, {31'h0, v && al});
        if (v && al) begin
            chk(mem_addr === a[31:2], "R1", {2'b0, mem_addr}, {2'b0, a[31:2]});
            chk(mem_we === w, "R1", {31'h0, mem_we}, {31'h0, w});
        end
        if (v && al && w) begin
            case (sz)
                2'd0: begin ebe = 4'b1000 >> k; ewd = {24'h0, wd[7:0]} << (8*(3-k)); end
                2'd1: begin ebe = 4'b1100 >> k; ewd = {16'h0, wd[15:0]} << (8*(2-k)); end
                default: begin ebe = 4'b1111; ewd = wd; end
            endcase
            chk(mem_be === ebe, sz == 2'd0 ? "R2" : sz == 2'd1 ? "R3" : sz == 2'd2 ? "R4" : "R12",
                {28'h0, mem_be}, {28'h0, ebe});
            chk(mem_wdata === ewd, sz == 2'd0 ? "R2" : sz == 2'd1 ? "R3" : sz == 2'd2 ? "R4" : "R12",
                mem_wdata, ewd);
            case (sz)
                2'd0: ref_bytes[a[5:0]] = wd[7:0];
                2'd1: begin ref_bytes[a[5:0]] = wd[15:8]; ref_bytes[a[5:0]+1] = wd[7:0]; end
                default: for (int j = 0; j < 4; j++) ref_bytes[a[5:0]+j] = wd[31-8*j -: 8];
            endcase
        end else begin
            chk(mem_be === 4'b0000, v ? "R10" : "R1", {28'h0, mem_be}, 32'h0);
        end
        exp_vld  = v && al && !w;
        exp_mis  = v && !al;
        exp_data = ref_load(sz, uns, a);
        exp_tag  = ld_tag(sz, uns);
    endtask

    task automatic idle();
        issue(1'b0, 1'b0, 2'd0, 1'b0, 32'h0, 32'h0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=%08h expected=%08h", 32'h0, 32'h1);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 64; i++) ref_bytes[i] = 8'(i * 37 + 5);
        for (int w = 0; w < 16; w++)
            mem_words[w] = {ref_bytes[4*w], ref_bytes[4*w+1], ref_bytes[4*w+2], ref_bytes[4*w+3]};

        // R11: reset state
        repeat (3) @(negedge clk);
        chk(ld_valid === 1'b0, "R11", {31'h0, ld_valid}, 32'h0);
        chk(misalign === 1'b0, "R11", {31'h0, misalign}, 32'h0);
        rst_n = 1'b1;
        idle();

        // R5 R6 R7 R8: loads of every size and offset over the initial pattern
        for (int k = 0; k < 4; k++) begin
            issue(1, 0, 2'd0, 0, 32'h10 + k, 0);   // R5
            issue(1, 0, 2'd0, 1, 32'h10 + k, 0);   // R6
        end
        issue(1, 0, 2'd1, 0, 32'h14, 0);           // R7
        issue(1, 0, 2'd1, 0, 32'h16, 0);           // R7
        issue(1, 1'b0, 2'd1, 1, 32'h16, 0);        // R6
        issue(1, 0, 2'd2, 0, 32'h18, 0);           // R8

        // R2: byte stores to each lane, then read back the word
        for (int k = 0; k < 4; k++) issue(1, 1, 2'd0, 0, 32'h20 + k, 32'hDEAD_BE80 + k);
        issue(1, 0, 2'd2, 0, 32'h20, 0);
        // R3: halfword stores, both positions
        issue(1, 1, 2'd1, 0, 32'h24, 32'h1234_9ABC);
        issue(1, 1, 2'd1, 0, 32'h26, 32'h5678_F00D);
        issue(1, 0, 2'd2, 0, 32'h24, 0);
        issue(1, 0, 2'd1, 0, 32'h26, 0);            // R7 negative halfword
        // R4: word store with high address bits set, read back via bytes
        issue(1, 1, 2'd2, 0, 32'hABCD_0028, 32'h8172_6354);
        issue(1, 0, 2'd0, 0, 32'h0000_0028, 0);
        issue(1, 0, 2'd0, 1, 32'h0000_002B, 0);
        // R12: size code 3 as word
        issue(1, 1, 2'd3, 0, 32'h2C, 32'hCAFE_F00D);
        issue(1, 0, 2'd3, 0, 32'h2C, 0);
        issue(1, 1, 2'd3, 0, 32'h2E, 32'h1111_1111); // misaligned as word
        // R10: misaligned stores leave memory untouched; then read back
        issue(1, 1, 2'd1, 0, 32'h31, 32'hFFFF_FFFF);
        issue(1, 1, 2'd2, 0, 32'h32, 32'hFFFF_FFFF);
        issue(1, 1, 2'd2, 0, 32'h33, 32'hFFFF_FFFF);
        issue(1, 0, 2'd2, 0, 32'h30, 0);
        issue(1, 0, 2'd1, 0, 32'h2D, 0);
        issue(1, 0, 2'd2, 0, 32'h31, 0);
        idle();

        // Mixed traffic
        for (int n = 0; n < 400; n++) begin
            logic [31:0] a;
            a = {$urandom_range(0, 3) == 0 ? 26'($urandom) : 26'h0, 6'($urandom)};
            if ((a[5:0] & 6'h3) != 0 && a[5:2] == 4'hF) a[5:0] = 6'h3C;
            issue($urandom_range(0, 5) != 0, 1'($urandom), 2'($urandom), 1'($urandom),
                  a, $urandom);
        end
        idle();
        idle();

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule